// File: doc/BRIEF.md
# Receive Elastic Slip Buffer

This block decouples a line-side receive byte stream from a system-side backplane stream. Channel bytes arrive on the write clock, recovered from the line. They go into a 64-slot store that holds two frames of 32 channels, one byte each. The system clock reads them back out in slot order. Each read returns the byte, its channel number and a frame-start marker. The write position crosses to the read clock as a Gray code through a synchronizer, so the two clocks may be unrelated.

Each time a read lands on the first channel of a frame, the block measures the lag in channels. The lag is the write slot minus the read slot, modulo 64.

- **Lag of 2 or less:** the reader is about to overtake fresh data. The reader replays the previous frame and the lag rises by 32.
- **Lag of 60 or more:** the writer is about to overrun unread data. One frame is skipped and the lag falls by 32.

Either adjustment is called a slip. A slip inverts a toggle output, records its direction, and sets a sticky status bit. That bit raises an interrupt unless the interrupt is masked.

Top module: `rx_slip_buffer`

## Requirements
- R1: A read strobe returns, one read-clock cycle later, the byte stored in the slot being read. `rd_chan` carries the slot index modulo 32. `rd_fstart` is 1 exactly when that index is 0. Successive reads advance one slot, modulo 64.
- R2: After reset the write slot is 0 and the read slot is 32, so the first read returns slot 32. `slip_toggle`, `slip_dir`, `slip_pending` and `slip_irq` are all 0.
- R3: A read at a frame start (slot modulo 32 equal to 0) with a lag of 2 or less is an underflow slip. It reads slot (read slot + 32) modulo 64, repeating a frame, so the lag becomes the old lag + 32. `slip_dir` becomes 1.
- R4: A read at a frame start with a lag of 60 or more is an overflow slip. It reads slot (read slot + 32) modulo 64, dropping a frame, so the lag becomes the old lag − 32. `slip_dir` becomes 0.
- R5: A frame-start read with a lag from 3 to 59 causes no slip. A read at any other channel never slips, whatever the lag.
- R6: `slip_toggle` inverts once for every slip and otherwise holds.
- R7: `slip_pending` is set by every slip and holds until a one-cycle `int_clr` pulse clears it. A clear in the same cycle as a slip leaves it set.
- R8: `slip_irq` is 1 exactly when `slip_pending` is 1 and `int_mask` is 0.
- R9: The write slot crosses into the read domain as a Gray code that changes by at most one bit per write. The lag reflects a write no more than three read-clock edges later. With reads and writes running together at a lag near 32, no slip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line-side write clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe: store `wr_data` in the current write slot |
| wr_data | input | 8 | Incoming channel byte |
| rd_clk | input | 1 | System-side read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read strobe: fetch the next slot |
| int_mask | input | 1 | 1 blocks the slip interrupt |
| int_clr | input | 1 | One-cycle pulse clearing `slip_pending` |
| rd_data | output | 8 | Byte fetched by the last read |
| rd_chan | output | 5 | Channel number of the last read |
| rd_fstart | output | 1 | Last read was channel 0 |
| slip_toggle | output | 1 | Inverts on each slip |
| slip_dir | output | 1 | Direction of the last slip: 1 repeated, 0 dropped |
| slip_pending | output | 1 | Sticky slip status |
| slip_irq | output | 1 | Slip interrupt request |

## Verification
A slip and a status clear can land on the same read-clock edge, and the bench provokes this directly. It sets the lag to 2, waits for the settle time, then drives `int_clr` together with the read strobe that falls on a frame start. The collision is judged correct if `slip_toggle` inverts and `slip_pending` stays at 1. A later lone clear must then drop `slip_pending`. Reads and writes in the same cycle are a second overlap, exercised by a long lockstep run at a lag of 32, in which every byte must match and no slip may appear.

// File: rtl/slip_pkg.sv
// Shared types for the receive slip buffer.
// Assumes: read-domain logic imports this package for slip classification.
package slip_pkg;

    // Outcome of evaluating a read strobe against the lag window.
    typedef enum logic [1:0] {
        SLIP_NONE  = 2'd0,
        SLIP_UNDER = 2'd1,
        SLIP_OVER  = 2'd2
    } slip_kind_e;

    // Encoding of the direction output.
    localparam logic DIR_DROPPED  = 1'b0;
    localparam logic DIR_REPEATED = 1'b1;

endpackage

// File: rtl/slip_wr_ptr.sv
// Write-side slot counter for the slip buffer.
// Counts one slot per write strobe, modulo the store size, and keeps a
// registered Gray image of the counter for crossing to the read clock.
// Assumes: the first accepted byte after reset belongs to channel 0.
module slip_wr_ptr #(
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_gray
);

    logic [ADDR_W-1:0] nxt_addr;

    // Next slot after the current write.
    assign nxt_addr = wr_addr + ADDR_W'(1);

    // Advance the binary slot and its Gray image together.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_addr <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wr_addr <= nxt_addr;
            wr_gray <= nxt_addr ^ (nxt_addr >> 1);
        end
    end

    // R9: the crossing value never changes in more than one bit per edge.
    assert_gray_single_step_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

// File: rtl/slip_gray_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer, with Gray-to-binary
// conversion on the destination side.
// Assumes: the source changes by at most one bit per source clock edge.
module slip_gray_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the Gray value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Fold the last stage back to binary, most significant bit first.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            acc        = acc ^ stage_q[STAGES-1][i];
            bin_out[i] = acc;
        end
    end

endmodule

// File: rtl/slip_store.sv
// Two-clock byte store: one write port on the line clock, one registered
// read port on the system clock.
// Assumes: contents need no reset; readers only consume written slots.
module slip_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Capture an incoming byte in its slot.
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch the requested slot into the output register.
    always_ff @(posedge rd_clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/slip_ctrl.sv
// Read-side control: read slot, lag window check at frame starts, frame
// slip adjustment and slip status outputs.
// Assumes: wr_seen is the synchronized write slot in binary form.
module slip_ctrl
    import slip_pkg::*;
#(
    parameter int CHAN_BITS = 5,
    parameter int UNDER_TH  = 2,
    parameter int OVER_TH   = 60
) (
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 rd_en,
    input  logic [CHAN_BITS:0]   wr_seen,
    input  logic                 int_mask,
    input  logic                 int_clr,
    output logic [CHAN_BITS:0]   rd_addr,
    output logic [CHAN_BITS-1:0] rd_chan,
    output logic                 rd_fstart,
    output logic                 slip_toggle,
    output logic                 slip_dir,
    output logic                 slip_pending,
    output logic                 slip_irq
);

    localparam int                ADDR_W     = CHAN_BITS + 1;
    localparam logic [ADDR_W-1:0] FRAME_STEP = {1'b1, {CHAN_BITS{1'b0}}};
    localparam logic [ADDR_W-1:0] UNDER_L    = ADDR_W'(UNDER_TH);
    localparam logic [ADDR_W-1:0] OVER_L     = ADDR_W'(OVER_TH);

    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] lag;
    logic              at_frame_start;
    slip_kind_e        kind;

    // Classify the current read against the lag window.
    always_comb begin
        lag            = wr_seen - rd_ptr;
        at_frame_start = (rd_ptr[CHAN_BITS-1:0] == '0);
        kind           = SLIP_NONE;
        if (rd_en && at_frame_start) begin
            if (lag <= UNDER_L)     kind = SLIP_UNDER;
            else if (lag >= OVER_L) kind = SLIP_OVER;
        end
        // Plus or minus one frame is the same move modulo two frames.
        rd_addr = (kind == SLIP_NONE) ? rd_ptr : (rd_ptr ^ FRAME_STEP);
    end

    // Advance the read slot and publish the channel markers.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_ptr    <= FRAME_STEP;
            rd_chan   <= '0;
            rd_fstart <= 1'b0;
        end else if (rd_en) begin
            rd_ptr    <= rd_addr + ADDR_W'(1);
            rd_chan   <= rd_addr[CHAN_BITS-1:0];
            rd_fstart <= (rd_addr[CHAN_BITS-1:0] == '0);
        end
    end

    // Record each slip: toggle, direction and sticky status.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            slip_toggle  <= 1'b0;
            slip_dir     <= DIR_DROPPED;
            slip_pending <= 1'b0;
        end else if (kind != SLIP_NONE) begin
            slip_toggle  <= ~slip_toggle;
            slip_dir     <= (kind == SLIP_UNDER) ? DIR_REPEATED : DIR_DROPPED;
            slip_pending <= 1'b1;
        end else if (int_clr) begin
            slip_pending <= 1'b0;
        end
    end

    // Interrupt request gated by the mask.
    assign slip_irq = slip_pending & ~int_mask;

    // R5: a slip only follows a read at a frame start.
    assert_slip_at_frame_start_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$stable(slip_toggle) |-> ($past(rd_en) && ($past(rd_ptr[CHAN_BITS-1:0]) == '0)));

    // R3: a repeat slip only when the lag was at or below the low bound.
    assert_repeat_needs_low_lag_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!$stable(slip_toggle) && slip_dir) |-> ($past(lag) <= UNDER_L));

    // R4: a drop slip only when the lag was at or above the high bound.
    assert_drop_needs_high_lag_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!$stable(slip_toggle) && !slip_dir) |-> ($past(lag) >= OVER_L));

    // R7: every slip leaves the status set.
    assert_status_on_slip_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$stable(slip_toggle) |-> slip_pending);

    // R7: the status only falls after a clear pulse.
    assert_status_clear_source_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $fell(slip_pending) |-> $past(int_clr));

    // R8: a masked interrupt never reaches the output.
    assert_irq_masked_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        int_mask |-> !slip_irq);

endmodule

// File: rtl/rx_slip_buffer.sv
// Receive elastic slip buffer: two-frame store between line and system
// timing, with frame-boundary slip control and slip reporting.
// Assumes: each domain has its own synchronous active-low reset, and both
// resets are applied together.
module rx_slip_buffer #(
    parameter int DATA_W      = 8,
    parameter int CHAN_BITS   = 5,
    parameter int UNDER_TH    = 2,
    parameter int OVER_TH     = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 rd_en,
    input  logic                 int_mask,
    input  logic                 int_clr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [CHAN_BITS-1:0] rd_chan,
    output logic                 rd_fstart,
    output logic                 slip_toggle,
    output logic                 slip_dir,
    output logic                 slip_pending,
    output logic                 slip_irq
);

    localparam int ADDR_W = CHAN_BITS + 1;

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] wr_gray;
    logic [ADDR_W-1:0] wr_seen;
    logic [ADDR_W-1:0] rd_addr;

    slip_wr_ptr #(.ADDR_W(ADDR_W)) u_wptr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_gray  (wr_gray)
    );

    slip_gray_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_gray),
        .bin_out (wr_seen)
    );

    slip_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    slip_ctrl #(.CHAN_BITS(CHAN_BITS), .UNDER_TH(UNDER_TH), .OVER_TH(OVER_TH)) u_ctrl (
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_en        (rd_en),
        .wr_seen      (wr_seen),
        .int_mask     (int_mask),
        .int_clr      (int_clr),
        .rd_addr      (rd_addr),
        .rd_chan      (rd_chan),
        .rd_fstart    (rd_fstart),
        .slip_toggle  (slip_toggle),
        .slip_dir     (slip_dir),
        .slip_pending (slip_pending),
        .slip_irq     (slip_irq)
    );

endmodule

// File: tb/sim_rx_slip_buffer.sv
`timescale 1ns/1ps
// Directed bench for the receive slip buffer; both domains share one clock.
module sim_rx_slip_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, int_mask = 1'b0, int_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] rd_chan;
    logic       rd_fstart, slip_toggle, slip_dir, slip_pending, slip_irq;

    always #2.5 clk = ~clk;

    rx_slip_buffer u0 (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en),
        .int_mask(int_mask), .int_clr(int_clr),
        .rd_data(rd_data), .rd_chan(rd_chan), .rd_fstart(rd_fstart),
        .slip_toggle(slip_toggle), .slip_dir(slip_dir),
        .slip_pending(slip_pending), .slip_irq(slip_irq)
    );

    int         n_chk = 0, n_bad = 0;
    logic [7:0] m_mem [64];
    int         m_wr = 0, m_rd = 32, seq = 0;
    bit         m_tog = 0, m_dir = 0, m_pend = 0;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 29 + 7);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock of stimulus with a requirement-level model of the outcome.
    task automatic cycle(bit w, bit r, bit c);
        int addr = m_rd;
        int lag  = (m_wr - m_rd) & 63;
        int kind = 0;
        logic [7:0] d, exp_d;
        if (r && (m_rd % 32) == 0) begin
            if (lag <= 2) kind = 1;
            else if (lag >= 60) kind = 2;
        end
        if (kind != 0) addr = (m_rd + 32) & 63;
        exp_d = m_mem[addr];
        d = pat(seq);
        wr_en = w; wr_data = d; rd_en = r; int_clr = c;
        @(negedge clk);
        wr_en = 0; rd_en = 0; int_clr = 0;
        if (w) begin m_mem[m_wr] = d; m_wr = (m_wr + 1) & 63; seq++; end
        if (r) m_rd = (addr + 1) & 63;
        if (kind != 0) begin m_tog = ~m_tog; m_dir = (kind == 1); m_pend = 1; end
        else if (c) m_pend = 0;
        if (r) begin
            chk(rd_data === exp_d, "R1 read data", int'(rd_data), int'(exp_d));
            chk(rd_chan == 5'(addr % 32), "R1 channel", int'(rd_chan), addr % 32);
            chk(rd_fstart == ((addr % 32) == 0), "R1 frame start", int'(rd_fstart), int'((addr % 32) == 0));
        end
        chk(slip_toggle == m_tog, "R6 toggle", int'(slip_toggle), int'(m_tog));
        chk(slip_dir == m_dir, "R3 R4 direction", int'(slip_dir), int'(m_dir));
        chk(slip_pending == m_pend, "R7 pending", int'(slip_pending), int'(m_pend));
        chk(slip_irq == (m_pend & ~int_mask), "R8 irq", int'(slip_irq), int'(m_pend & ~int_mask));
    endtask

    task automatic to_boundary();
        while ((m_rd % 32) != 0) cycle(0, 1, 0);
    endtask

    // Write enough bytes to reach the target lag, then let the crossing settle.
    task automatic set_lag(int target);
        int n = (m_rd + target - m_wr) & 63;
        repeat (n) cycle(1, 0, 0);
        repeat (4) cycle(0, 0, 0);
    endtask

    // Frame-start read with an expected slip kind: 0 none, 1 repeat, 2 drop.
    task automatic bound_read(int exp_kind, bit c, string tag);
        bit prev = slip_toggle;
        cycle(0, 1, c);
        chk((slip_toggle != prev) == (exp_kind != 0), tag, int'(slip_toggle != prev), int'(exp_kind != 0));
        if (exp_kind != 0)
            chk(slip_dir == (exp_kind == 1), tag, int'(slip_dir), int'(exp_kind == 1));
    endtask

    task automatic t_reset();
        chk(slip_toggle == 0, "R2 toggle at reset", int'(slip_toggle), 0);
        chk(slip_dir == 0, "R2 dir at reset", int'(slip_dir), 0);
        chk(slip_pending == 0, "R2 pending at reset", int'(slip_pending), 0);
        chk(slip_irq == 0, "R2 irq at reset", int'(slip_irq), 0);
    endtask

    task automatic t_prefill();
        repeat (64) cycle(1, 0, 0);
        repeat (4) cycle(0, 0, 0);
        cycle(0, 1, 0);
        chk(rd_data == pat(32) && rd_chan == 0, "R2 first read is slot 32", int'(rd_data), int'(pat(32)));
        repeat (31) cycle(0, 1, 0);
    endtask

    task automatic t_underflow();
        to_boundary(); set_lag(3);
        bound_read(0, 0, "R5 lag 3 no slip");
        to_boundary(); set_lag(2);
        bound_read(1, 0, "R3 lag 2 repeats frame");
        to_boundary();
        bound_read(1, 0, "R3 landed at lag 34");
    endtask

    task automatic t_mask_clear();
        int_mask = 1; @(negedge clk);
        chk(slip_irq == 0, "R8 masked irq", int'(slip_irq), 0);
        chk(slip_pending == 1, "R7 pending held", int'(slip_pending), 1);
        int_mask = 0; @(negedge clk);
        chk(slip_irq == 1, "R8 unmasked irq", int'(slip_irq), 1);
        cycle(0, 0, 1);
        chk(slip_pending == 0, "R7 cleared by pulse", int'(slip_pending), 0);
    endtask

    task automatic t_overflow();
        to_boundary(); set_lag(59);
        bound_read(0, 0, "R5 lag 59 no slip");
        to_boundary(); set_lag(60);
        bound_read(2, 0, "R4 lag 60 drops frame");
        to_boundary();
        bound_read(2, 0, "R4 landed at lag 28");
    endtask

    task automatic t_collide();
        cycle(0, 0, 1);
        to_boundary(); set_lag(2);
        bound_read(1, 1, "R7 slip with clear");
        chk(slip_pending == 1, "R7 clear loses to slip", int'(slip_pending), 1);
        cycle(0, 0, 1);
        chk(slip_pending == 0, "R7 lone clear", int'(slip_pending), 0);
    endtask

    task automatic t_mid_frame();
        bit prev;
        to_boundary(); set_lag(12);
        prev = slip_toggle;
        bound_read(0, 0, "R5 lag 12 no slip");
        repeat (20) cycle(0, 1, 0);
        chk(slip_toggle == prev, "R5 no slip mid-frame", int'(slip_toggle), int'(prev));
    endtask

    task automatic t_lockstep();
        bit prev;
        to_boundary(); set_lag(32);
        prev = slip_toggle;
        repeat (96) cycle(1, 1, 0);
        chk(slip_toggle == prev, "R9 no slip when locked", int'(slip_toggle), int'(prev));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_prefill();
        t_underflow();
        t_mask_clear();
        t_overflow();
        t_collide();
        t_mid_frame();
        t_lockstep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule